// File: doc/BRIEF.md
# Bus-Master Memory Cycle Timer

This block times the memory read and write cycles that a DMA bus master issues on a 16-bit ISA-style system bus. A cycle request comes with a direction bit. The block then raises the matching command strobe for an active phase. An idle phase follows, and it must end before the bus can carry another command. Both phases are counted in ticks of the block clock. At the intended 20 MHz reference, one tick is 50 ns.

The active phase is a base of five ticks (250 ns) plus a configurable number of extra ticks. The extra ticks lengthen the command for slow hosts. The idle phase is four ticks (200 ns) by default, or two ticks (100 ns) when the fast-idle bit is set. A slow target can hold the command open by pulling the ready input low. The block looks at ready only in the last active tick. A request that arrives while a cycle is running is held in a single-entry queue. It starts as soon as the idle phase ends. The block reports the end of each command with a one-clock done pulse and shows a busy flag for the whole cycle.

Top module: `mem_cycle_timer`

## Requirements
- R1: After reset, readStrobe, writeStrobe, cycleDone and busy are all low.
- R2: A request with reqWrite = 0, accepted at a clock edge while the block is free, raises readStrobe from that edge for exactly 5 + extraTicks clocks. writeStrobe stays low for the whole cycle. With extraTicks = 0 this is 5 clocks.
- R3: A request with reqWrite = 1 raises writeStrobe in the same way and leaves readStrobe low. The two strobes are never high together, and neither is high while busy is low.
- R4: extraTicks lengthens the active phase by one clock per unit. Values 1, 2 and 3 give 6, 7 and 8 clocks.
- R5: busy rises with the strobe and stays high through the idle phase after the strobe falls. With fastIdle = 0 the idle phase lasts 4 clocks, so busy is high for 5 + extraTicks + 4 clocks. With fastIdle = 1 it lasts 2 clocks.
- R6: busReady is sampled only at the edge that ends the last active tick. Each such edge with busReady low holds the strobe for one more clock. busReady low at any earlier active edge has no effect.
- R7: cycleDone is high for exactly one clock per cycle: the clock right after the strobe falls, which is the first idle clock.
- R8: A request that arrives while busy is high is queued, up to one entry. It raises its strobe in the clock right after the previous idle phase ends, so busy stays high throughout. A further request that arrives while the queue is full is dropped.
- R9: extraTicks and fastIdle are captured when a cycle starts. Changing them during the cycle does not change that cycle's active or idle length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; one period is one tick |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | One-clock pulse that requests a memory cycle |
| reqWrite | input | 1 | Direction of the requested cycle: 1 write, 0 read |
| extraTicks | input | EXTRA_W (2) | Extra active-phase ticks added to the base of 5 |
| fastIdle | input | 1 | 1 selects a 2-tick idle phase, 0 selects 4 ticks |
| busReady | input | 1 | Bus ready; low in the last active tick extends the command |
| readStrobe | output | 1 | Memory read command, high during a read active phase |
| writeStrobe | output | 1 | Memory write command, high during a write active phase |
| cycleDone | output | 1 | One-clock pulse in the first idle clock of each cycle |
| busy | output | 1 | High from the start of the active phase to the end of idle |

## Verification
Timing is counted from the edge that samples a request as edge 0. The strobe is high after edges 0 through N-1, where N = 5 + extraTicks + the number of low-ready clocks. cycleDone is high in sample N+1. busy is high in samples 1 through N plus the idle length. The bench drives every input at a falling edge and samples every output at the next falling edge, so each sample index maps to one rising edge. Ready stalls, mid-cycle configuration changes and queued requests are all placed at fixed sample indices relative to that count.

// File: rtl/mct_pkg.sv
package mct_pkg;

  typedef enum logic [1:0] {
    PH_FREE   = 2'd0,
    PH_ACTIVE = 2'd1,
    PH_IDLE   = 2'd2
  } phase_t;

  typedef struct packed {
    logic takeNew;
    logic takePend;
    logic cntClr;
    logic cntInc;
    logic endActive;
  } ctrlStrb_t;

endpackage

// File: rtl/mct_datapath.sv
module mct_datapath
  import mct_pkg::*;
#(
  parameter int BASE_TICKS = 5,
  parameter int EXTRA_W    = 2,
  parameter int IDLE_SLOW  = 4,
  parameter int IDLE_FAST  = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrb_t          strb,
  input  logic               reqValid,
  input  logic               reqWrite,
  input  logic [EXTRA_W-1:0] extraTicks,
  input  logic               fastIdle,
  output logic               activeLast,
  output logic               idleLast,
  output logic               pendValid,
  output logic               curWrite,
  output logic               doneQ
);

  localparam int MAX_ACTIVE = BASE_TICKS + (1 << EXTRA_W) - 1;
  localparam int MAX_LEN    = (MAX_ACTIVE > IDLE_SLOW) ? MAX_ACTIVE : IDLE_SLOW;
  localparam int CNT_W      = $clog2(MAX_LEN + 1);

  logic [CNT_W-1:0]   tickCnt;
  logic [EXTRA_W-1:0] curExtra;
  logic               curFast;
  logic               pendWrite;
  logic [EXTRA_W-1:0] startExtra;
  logic               startFast;
  logic               startWrite;
  logic [CNT_W-1:0]   activeLen;
  logic [CNT_W-1:0]   idleLen;

  // Configuration and direction for a starting cycle
  always_comb begin
    startExtra = extraTicks;
    startFast  = fastIdle;
    startWrite = strb.takePend ? pendWrite : reqWrite;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curExtra <= '0;
      curFast  <= 1'b0;
      curWrite <= 1'b0;
    end else if (strb.takeNew || strb.takePend) begin
      curExtra <= startExtra;
      curFast  <= startFast;
      curWrite <= startWrite;
    end
  end

  // Single-entry request queue
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendValid <= 1'b0;
      pendWrite <= 1'b0;
    end else if (strb.takePend) begin
      pendValid <= reqValid;
      if (reqValid) pendWrite <= reqWrite;
    end else if (reqValid && !strb.takeNew && !pendValid) begin
      pendValid <= 1'b1;
      pendWrite <= reqWrite;
    end
  end

  // Tick counter shared by both phases
  always_ff @(posedge clk) begin
    if (!rstN) begin
      tickCnt <= '0;
    end else if (strb.cntClr) begin
      tickCnt <= '0;
    end else if (strb.cntInc) begin
      tickCnt <= tickCnt + 1'b1;
    end
  end

  always_comb begin
    activeLen  = CNT_W'(BASE_TICKS) + CNT_W'(curExtra);
    idleLen    = curFast ? CNT_W'(IDLE_FAST) : CNT_W'(IDLE_SLOW);
    activeLast = (tickCnt == activeLen - 1'b1);
    idleLast   = (tickCnt == idleLen - 1'b1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) doneQ <= 1'b0;
    else       doneQ <= strb.endActive;
  end

endmodule

// File: rtl/mct_ctrl.sv
module mct_ctrl
  import mct_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  logic      busReady,
  input  logic      activeLast,
  input  logic      idleLast,
  input  logic      pendValid,
  input  logic      curWrite,
  output ctrlStrb_t strb,
  output logic      readStrobe,
  output logic      writeStrobe,
  output logic      busy
);

  phase_t phase;
  phase_t phaseNext;

  always_comb begin
    phaseNext = phase;
    strb      = '0;
    case (phase)
      PH_FREE: begin
        if (pendValid) begin
          strb.takePend = 1'b1;
          strb.cntClr   = 1'b1;
          phaseNext     = PH_ACTIVE;
        end else if (reqValid) begin
          strb.takeNew = 1'b1;
          strb.cntClr  = 1'b1;
          phaseNext    = PH_ACTIVE;
        end
      end
      PH_ACTIVE: begin
        if (activeLast) begin
          if (busReady) begin
            strb.endActive = 1'b1;
            strb.cntClr    = 1'b1;
            phaseNext      = PH_IDLE;
          end
        end else begin
          strb.cntInc = 1'b1;
        end
      end
      PH_IDLE: begin
        if (idleLast) begin
          strb.cntClr = 1'b1;
          if (pendValid) begin
            strb.takePend = 1'b1;
            phaseNext     = PH_ACTIVE;
          end else if (reqValid) begin
            strb.takeNew = 1'b1;
            phaseNext    = PH_ACTIVE;
          end else begin
            phaseNext = PH_FREE;
          end
        end else begin
          strb.cntInc = 1'b1;
        end
      end
      default: phaseNext = PH_FREE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) phase <= PH_FREE;
    else       phase <= phaseNext;
  end

  always_comb begin
    readStrobe  = (phase == PH_ACTIVE) && !curWrite;
    writeStrobe = (phase == PH_ACTIVE) &&  curWrite;
    busy        = (phase != PH_FREE);
  end

endmodule

// File: rtl/mem_cycle_timer.sv
module mem_cycle_timer
  import mct_pkg::*;
#(
  parameter int BASE_TICKS = 5,
  parameter int EXTRA_W    = 2,
  parameter int IDLE_SLOW  = 4,
  parameter int IDLE_FAST  = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  logic               reqWrite,
  input  logic [EXTRA_W-1:0] extraTicks,
  input  logic               fastIdle,
  input  logic               busReady,
  output logic               readStrobe,
  output logic               writeStrobe,
  output logic               cycleDone,
  output logic               busy
);

  ctrlStrb_t strb;
  logic      activeLast;
  logic      idleLast;
  logic      pendValid;
  logic      curWrite;

  mct_ctrl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .busReady   (busReady),
    .activeLast (activeLast),
    .idleLast   (idleLast),
    .pendValid  (pendValid),
    .curWrite   (curWrite),
    .strb       (strb),
    .readStrobe (readStrobe),
    .writeStrobe(writeStrobe),
    .busy       (busy)
  );

  mct_datapath #(
    .BASE_TICKS(BASE_TICKS),
    .EXTRA_W   (EXTRA_W),
    .IDLE_SLOW (IDLE_SLOW),
    .IDLE_FAST (IDLE_FAST)
  ) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .reqValid  (reqValid),
    .reqWrite  (reqWrite),
    .extraTicks(extraTicks),
    .fastIdle  (fastIdle),
    .activeLast(activeLast),
    .idleLast  (idleLast),
    .pendValid (pendValid),
    .curWrite  (curWrite),
    .doneQ     (cycleDone)
  );

endmodule

// File: rtl/mct_checker.sv
module mct_checker #(
  parameter int BASE_TICKS = 5
) (
  input logic clk,
  input logic rstN,
  input logic busReady,
  input logic readStrobe,
  input logic writeStrobe,
  input logic cycleDone,
  input logic busy
);

  logic       anyStrobe;
  logic [7:0] runLen;

  assign anyStrobe = readStrobe || writeStrobe;

  always_ff @(posedge clk) begin
    if (!rstN)          runLen <= '0;
    else if (anyStrobe) runLen <= (runLen == 8'hff) ? runLen : runLen + 1'b1;
    else                runLen <= '0;
  end

  // R3: never both strobes
  a_r3_one_strobe: assert property (@(posedge clk) disable iff (!rstN)
    !(readStrobe && writeStrobe));

  // R3: no strobe outside a busy cycle
  a_r3_no_strobe_free: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !anyStrobe);

  // R2: the active phase is at least the base length
  a_r2_min_active: assert property (@(posedge clk) disable iff (!rstN)
    $fell(anyStrobe) |-> (runLen >= 8'(BASE_TICKS)));

  // R6: a strobe ends only after ready was high
  a_r6_end_on_ready: assert property (@(posedge clk) disable iff (!rstN)
    $fell(anyStrobe) |-> $past(busReady));

  // R7: done is a single clock
  a_r7_done_single: assert property (@(posedge clk) disable iff (!rstN)
    cycleDone |=> !cycleDone);

  // R7: done follows the end of a strobe
  a_r7_done_after_strobe: assert property (@(posedge clk) disable iff (!rstN)
    cycleDone |-> ($past(anyStrobe) && !anyStrobe && busy));

  // R5: idle holds busy after the strobe falls
  a_r5_busy_after_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $fell(anyStrobe) |-> busy);

endmodule

bind mem_cycle_timer mct_checker #(.BASE_TICKS(BASE_TICKS)) uChk (
  .clk        (clk),
  .rstN       (rstN),
  .busReady   (busReady),
  .readStrobe (readStrobe),
  .writeStrobe(writeStrobe),
  .cycleDone  (cycleDone),
  .busy       (busy)
);

// File: tb/mem_cycle_timer_test.sv
module mem_cycle_timer_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       reqValid = 1'b0;
  logic       reqWrite = 1'b0;
  logic [1:0] extraTicks = 2'd0;
  logic       fastIdle = 1'b0;
  logic       busReady = 1'b1;
  logic       readStrobe, writeStrobe, cycleDone, busy;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  mem_cycle_timer uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .extraTicks(extraTicks), .fastIdle(fastIdle), .busReady(busReady),
    .readStrobe(readStrobe), .writeStrobe(writeStrobe),
    .cycleDone(cycleDone), .busy(busy)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Issues one request and measures the cycle(s) it produces
  task automatic measure(input logic wr, input int extra, input logic fast,
                         input int lowFrom, input int lowLen, input bit earlyLow,
                         input bit queueTwo, input bit flipCfg,
                         output int rdCnt, output int wrCnt, output int busyCnt,
                         output int doneCnt, output int doneIdx, output int bothCnt);
    rdCnt = 0; wrCnt = 0; busyCnt = 0; doneCnt = 0; doneIdx = 0; bothCnt = 0;
    @(negedge clk);
    reqWrite = wr; extraTicks = 2'(extra); fastIdle = fast; reqValid = 1'b1;
    @(negedge clk);
    for (int k = 1; k < 200; k++) begin
      if (readStrobe) rdCnt++;
      if (writeStrobe) wrCnt++;
      if (readStrobe && writeStrobe) bothCnt++;
      if (busy) busyCnt++;
      if (!busy && (readStrobe || writeStrobe)) bothCnt++;
      if (cycleDone) begin
        doneCnt++;
        if (doneIdx == 0) doneIdx = k;
      end
      reqValid = 1'b0;
      busReady = 1'b1;
      if (queueTwo && k == 2) begin reqValid = 1'b1; reqWrite = !wr; end
      if (queueTwo && k == 3) begin reqValid = 1'b1; reqWrite = wr; end
      if (flipCfg && k == 2) begin extraTicks = ~2'(extra); fastIdle = !fast; end
      if (earlyLow && k == 2) busReady = 1'b0;
      if (k >= lowFrom && k < lowFrom + lowLen) busReady = 1'b0;
      if (!busy) break;
      @(negedge clk);
    end
    reqValid = 1'b0; busReady = 1'b1; extraTicks = 2'(extra); fastIdle = fast;
    repeat (2) @(negedge clk);
  endtask

  task automatic testReset;
    check(!readStrobe && !writeStrobe, "R1 strobes low", int'(readStrobe | writeStrobe), 0);
    check(!busy, "R1 busy low", int'(busy), 0);
    check(!cycleDone, "R1 done low", int'(cycleDone), 0);
  endtask

  task automatic testBasic(input logic wr, input int extra, input logic fast, input string tag);
    int rd, wc, bz, dc, di, bo, n, idl;
    n = 5 + extra; idl = fast ? 2 : 4;
    measure(wr, extra, fast, 0, 0, 1'b0, 1'b0, 1'b0, rd, wc, bz, dc, di, bo);
    check(rd == (wr ? 0 : n), {tag, " read strobe length"}, rd, wr ? 0 : n);
    check(wc == (wr ? n : 0), {tag, " write strobe length"}, wc, wr ? n : 0);
    check(bo == 0, "R3 strobe exclusive", bo, 0);
    check(bz == n + idl, "R5 busy length", bz, n + idl);
    check(dc == 1, "R7 done count", dc, 1);
    check(di == n + 1, "R7 done position", di, n + 1);
  endtask

  task automatic testReady(input int low);
    int rd, wc, bz, dc, di, bo;
    measure(1'b0, 0, 1'b0, 5, low, 1'b1, 1'b0, 1'b0, rd, wc, bz, dc, di, bo);
    check(rd == 5 + low, "R6 stretched strobe", rd, 5 + low);
    check(bz == 9 + low, "R6 stretched busy", bz, 9 + low);
    check(di == 6 + low, "R6 done after stretch", di, 6 + low);
  endtask

  task automatic testQueue;
    int rd, wc, bz, dc, di, bo;
    measure(1'b0, 0, 1'b0, 0, 0, 1'b0, 1'b1, 1'b0, rd, wc, bz, dc, di, bo);
    check(rd == 5, "R8 first cycle read only, third dropped", rd, 5);
    check(wc == 5, "R8 queued write cycle", wc, 5);
    check(bz == 18, "R8 busy continuous", bz, 18);
    check(dc == 2, "R8 two done pulses", dc, 2);
  endtask

  task automatic testCfgLatch;
    int rd, wc, bz, dc, di, bo;
    measure(1'b1, 1, 1'b0, 0, 0, 1'b0, 1'b0, 1'b1, rd, wc, bz, dc, di, bo);
    check(wc == 6, "R9 active length kept", wc, 6);
    check(bz == 10, "R9 idle length kept", bz, 10);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testBasic(1'b0, 0, 1'b0, "R2");
    testBasic(1'b1, 0, 1'b0, "R3");
    testBasic(1'b0, 1, 1'b0, "R4");
    testBasic(1'b1, 2, 1'b1, "R4");
    testBasic(1'b0, 3, 1'b1, "R5");
    testReady(1);
    testReady(3);
    testQueue();
    testCfgLatch();
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

endmodule